// File: doc/BRIEF.md
# Real-Time Clock Host Port and Interrupt Flags

This block is the host-facing front of a real-time clock. The host sees two byte addresses. A write to address 0 stores a 7-bit register index. A read or write at address 1 reaches the register that index selects. Most indices pass straight through to an external register file over a simple strobe interface. The block itself owns three registers:

- the control register at index 0x0B;
- the interrupt flag register at index 0x0C;
- the constant status register at index 0x0D.

It also masks the read-only update-in-progress bit of the rate register at index 0x0A.

Three one-cycle event strobes come from the clock and rate logic: end of update, alarm match and periodic tick. Each strobe sets its flag, whatever the enables hold. The flags are combined with the enables in the control register to form the interrupt request. A host read of the flag register returns the flags and then clears them. An event that arrives in the same cycle as that read is kept.

Top module: `rtc_host_port`

## Requirements
- R1: A write (`bus_wr`=1) at address 0 (`bus_addr`=0) stores `bus_wdata[6:0]` as the register index, visible on `ext_idx_o` after that clock edge.
- R2: A write at address 1 to any index other than 0x0B, 0x0C and 0x0D pulses `ext_wr_o` in the same cycle, with `ext_wdata_o` equal to `bus_wdata`. For index 0x0A, bit 7 of `ext_wdata_o` is forced to 0.
- R3: A read (`bus_rd`=1) at address 1 loads `bus_rdata` at the clock edge. For pass-through indices the value is `ext_rdata_i`. For index 0x0A the value is `{uip_i, ext_rdata_i[6:0]}`. A read at address 0 returns 0x00.
- R4: A write at address 1 to index 0x0B loads the control register. A read of index 0x0B returns it, and `ctrl_b_o` shows it. Control bit 3 is the square-wave enable, bit 4 is the update interrupt enable, bit 5 is the alarm interrupt enable and bit 6 is the periodic interrupt enable.
- R5: `evt_update_i`, `evt_alarm_i` and `evt_periodic_i` set flag bits 4, 5 and 6 of register 0x0C. This happens whether or not the matching enable is set.
- R6: Bit 7 of register 0x0C and `irq_o` both equal (bit4 AND enable4) OR (bit5 AND enable5) OR (bit6 AND enable6). Bits 3:0 of register 0x0C read as 0.
- R7: A read of index 0x0C returns the flags as they stood before the edge, and then clears all flags.
- R8: An event strobe in the same cycle as a read of index 0x0C leaves its flag set after the clear.
- R9: Writes to index 0x0C and 0x0D change nothing and produce no `ext_wr_o`.
- R10: After reset the index is 0, the control register is 0x00, all flags are 0, `irq_o` is 0, `bus_rdata` is 0x00, and index 0x0D reads as 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 selects the index register, 1 selects the data register |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, loaded at the edge of a read |
| ext_idx_o | output | 7 | Current register index, to the external register file |
| ext_wr_o | output | 1 | Write strobe to the external register file |
| ext_wdata_o | output | 8 | Write data to the external register file |
| ext_rdata_i | input | 8 | External register file contents at `ext_idx_o` |
| uip_i | input | 1 | Update-in-progress status from the clock logic |
| evt_update_i | input | 1 | End-of-update event strobe |
| evt_alarm_i | input | 1 | Alarm match event strobe |
| evt_periodic_i | input | 1 | Periodic tick event strobe |
| ctrl_b_o | output | 8 | Control register contents |
| irq_o | output | 1 | Interrupt request, high while the gated flag OR is 1 |

## Verification
Faults in this block's state show up at the ports as follows:

- **Stuck or dropped flag.** `irq_o` is wrong on the first edge after an event where the matching enable is set. Whether or not the enable is set, the next read of 0x0C shows the wrong bits.
- **Flag clear at the wrong time.** A clear that comes too early, or that drops a same-cycle event, is exposed by the read that follows.
- **Index latch error.** A wrong index shows at once on `ext_idx_o`, and as a misrouted strobe on `ext_wr_o`.

The bench checks `irq_o`, `ctrl_b_o` and the write strobes after every operation. Each fault therefore surfaces within one cycle of the operation that exposes it.

// File: rtl/rtc_host_pkg.sv
package rtc_host_pkg;
  localparam int IDX_W  = 7;
  localparam int DATA_W = 8;

  localparam logic [IDX_W-1:0] IDX_RATE  = 7'h0A;
  localparam logic [IDX_W-1:0] IDX_CTRL  = 7'h0B;
  localparam logic [IDX_W-1:0] IDX_FLAGS = 7'h0C;
  localparam logic [IDX_W-1:0] IDX_STAT  = 7'h0D;

  // control register enable positions
  localparam int CB_SQW = 3;
  localparam int CB_UEN = 4;
  localparam int CB_AEN = 5;
  localparam int CB_PEN = 6;

  // flag register field positions
  localparam int FL_LSB = 4;
  localparam int FL_IRQ = 7;
  localparam int UIP_BIT = 7;

  localparam logic [DATA_W-1:0] STAT_VALUE = 8'h80;

  typedef struct packed {
    logic pf;
    logic af;
    logic uf;
  } flags_t;
endpackage

// File: rtl/rtc_index_latch.sv
module rtc_index_latch
  import rtc_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [IDX_W-1:0] data_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (load_i) idx_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> idx_q == $past(data_i)); // R1
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] ctrl_o
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we_i) ctrl_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> ctrl_q == $past(data_i)); // R4
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(ctrl_q)); // R4
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
  import rtc_host_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   evt_update_i,
  input  logic   evt_alarm_i,
  input  logic   evt_periodic_i,
  input  logic   clr_i,
  input  logic   en_update_i,
  input  logic   en_alarm_i,
  input  logic   en_periodic_i,
  output flags_t flags_o,
  output logic   irqf_o
);
  flags_t flags_q, flags_d, set_vec, keep_vec;

  always_comb begin
    set_vec  = '{pf: evt_periodic_i, af: evt_alarm_i, uf: evt_update_i};
    keep_vec = clr_i ? '0 : flags_q;
    flags_d  = keep_vec | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;
  assign irqf_o  = (flags_q.uf & en_update_i) | (flags_q.af & en_alarm_i) |
                   (flags_q.pf & en_periodic_i);

  AST_UF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_update_i |=> flags_q.uf); // R5
  AST_AF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_alarm_i |=> flags_q.af); // R5
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !evt_update_i && !evt_alarm_i && !evt_periodic_i |=> flags_q == '0); // R7
  AST_CLR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && evt_periodic_i |=> flags_q.pf); // R8
  AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q == '0 |-> !irqf_o); // R6
endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
  import rtc_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [IDX_W-1:0]  ext_idx_o,
  output logic              ext_wr_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  input  logic [DATA_W-1:0] ext_rdata_i,
  input  logic              uip_i,
  input  logic              evt_update_i,
  input  logic              evt_alarm_i,
  input  logic              evt_periodic_i,
  output logic [DATA_W-1:0] ctrl_b_o,
  output logic              irq_o
);
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] ctrl;
  flags_t            flags;
  logic              irqf;
  logic              hit_rate, hit_ctrl, hit_flags, hit_stat, local_idx;
  logic              data_wr, data_rd;
  logic [DATA_W-1:0] rd_d, rdata_q;

  assign hit_rate  = (idx == IDX_RATE);
  assign hit_ctrl  = (idx == IDX_CTRL);
  assign hit_flags = (idx == IDX_FLAGS);
  assign hit_stat  = (idx == IDX_STAT);
  assign local_idx = hit_ctrl | hit_flags | hit_stat;
  assign data_wr   = bus_wr & bus_addr;
  assign data_rd   = bus_rd & bus_addr;

  rtc_index_latch u_idx (
    .clk(clk), .rst_n(rst_n),
    .load_i(bus_wr & ~bus_addr),
    .data_i(bus_wdata[IDX_W-1:0]),
    .idx_o(idx)
  );

  rtc_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .we_i(data_wr & hit_ctrl),
    .data_i(bus_wdata),
    .ctrl_o(ctrl)
  );

  rtc_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n),
    .evt_update_i(evt_update_i),
    .evt_alarm_i(evt_alarm_i),
    .evt_periodic_i(evt_periodic_i),
    .clr_i(data_rd & hit_flags),
    .en_update_i(ctrl[CB_UEN]),
    .en_alarm_i(ctrl[CB_AEN]),
    .en_periodic_i(ctrl[CB_PEN]),
    .flags_o(flags),
    .irqf_o(irqf)
  );

  // pass-through write path, update-in-progress bit masked for the rate register
  always_comb begin
    ext_wdata_o = bus_wdata;
    if (hit_rate) ext_wdata_o[UIP_BIT] = 1'b0;
  end
  assign ext_wr_o  = data_wr & ~local_idx;
  assign ext_idx_o = idx;

  // read mux
  always_comb begin
    rd_d = '0;
    if (bus_addr) begin
      if (hit_ctrl) begin
        rd_d = ctrl;
      end else if (hit_flags) begin
        rd_d = '0;
        rd_d[FL_LSB +: 3] = flags;
        rd_d[FL_IRQ] = irqf;
      end else if (hit_stat) begin
        rd_d = STAT_VALUE;
      end else begin
        rd_d = ext_rdata_i;
        if (hit_rate) rd_d[UIP_BIT] = uip_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_d;
  end

  assign bus_rdata = rdata_q;
  assign ctrl_b_o  = ctrl;
  assign irq_o     = irqf;

  AST_LOCAL_NO_EXT_WR: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && (hit_flags || hit_stat) |-> !ext_wr_o); // R9
  AST_RATE_UIP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_o && hit_rate |-> !ext_wdata_o[UIP_BIT]); // R2
  AST_IDX0_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_addr |=> bus_rdata == '0); // R3
  AST_STAT_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr && hit_stat |=> bus_rdata == 8'h80); // R10
endmodule

// File: tb/rtc_host_port_tb.sv
module rtc_host_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_addr, bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic [6:0] ext_idx_o;
  logic       ext_wr_o;
  logic [7:0] ext_wdata_o, ext_rdata_i;
  logic       uip_i, evt_update_i, evt_alarm_i, evt_periodic_i;
  logic [7:0] ctrl_b_o;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] ext_mem [128];
  logic [7:0] m_mem [128];
  logic [6:0] m_idx;
  logic [7:0] m_ctrl;
  logic [2:0] m_flags; // {pf, af, uf}

  always #4 clk = ~clk;

  rtc_host_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_idx_o(ext_idx_o), .ext_wr_o(ext_wr_o),
    .ext_wdata_o(ext_wdata_o), .ext_rdata_i(ext_rdata_i), .uip_i(uip_i),
    .evt_update_i(evt_update_i), .evt_alarm_i(evt_alarm_i), .evt_periodic_i(evt_periodic_i),
    .ctrl_b_o(ctrl_b_o), .irq_o(irq_o)
  );

  // stand-in external register file
  assign ext_rdata_i = ext_mem[ext_idx_o];
  always @(posedge clk) if (ext_wr_o) ext_mem[ext_idx_o] <= ext_wdata_o;

  function automatic logic exp_irq(logic [2:0] f, logic [7:0] c);
    return (f[0] & c[4]) | (f[1] & c[5]) | (f[2] & c[6]);
  endfunction

  function automatic logic [7:0] exp_read(logic a, logic [6:0] i, logic u);
    if (!a) return 8'h00;
    case (i)
      7'h0B: return m_ctrl;
      7'h0C: return {exp_irq(m_flags, m_ctrl), m_flags, 4'h0};
      7'h0D: return 8'h80;
      7'h0A: return {u, m_mem[i][6:0]};
      default: return m_mem[i];
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(logic a, logic w, logic r, logic [7:0] d, logic [2:0] ev, logic u);
    logic [7:0] er;
    logic       ewr;
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d; uip_i = u;
    evt_update_i = ev[0]; evt_alarm_i = ev[1]; evt_periodic_i = ev[2];
    #1;
    ewr = w && a && !(m_idx inside {7'h0B, 7'h0C, 7'h0D});
    chk(m_idx inside {7'h0C, 7'h0D} ? "R9 ext_wr" : "R2 ext_wr", ext_wr_o, ewr);
    if (ewr) chk("R2 ext_wdata", ext_wdata_o, (m_idx == 7'h0A) ? {1'b0, d[6:0]} : d);
    er = exp_read(a, m_idx, u);
    // model update at the edge
    if (w && !a) m_idx = d[6:0];
    if (ewr) m_mem[m_idx] = (m_idx == 7'h0A) ? {1'b0, d[6:0]} : d;
    if (w && a && m_idx == 7'h0B) m_ctrl = d;
    if (r && a && m_idx == 7'h0C) m_flags = 3'b000;
    m_flags = m_flags | {ev[2], ev[1], ev[0]};
    @(posedge clk); #1;
    if (r) chk((a && m_idx == 7'h0C) ? "R7 read flags" : "R3 read data", bus_rdata, er);
    chk("R1 index", ext_idx_o, m_idx);
    chk("R4 ctrl", ctrl_b_o, m_ctrl);
    chk("R6 irq", irq_o, exp_irq(m_flags, m_ctrl));
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    evt_update_i = 0; evt_alarm_i = 0; evt_periodic_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 128; i++) begin
      ext_mem[i] = 8'(i * 3 + 1);
      m_mem[i] = 8'(i * 3 + 1);
    end
    m_idx = 0; m_ctrl = 0; m_flags = 0;
    rst_n = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; uip_i = 0;
    evt_update_i = 0; evt_alarm_i = 0; evt_periodic_i = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset rdata", bus_rdata, 8'h00);
    chk("R10 reset idx", ext_idx_o, 7'h00);
    chk("R10 reset ctrl", ctrl_b_o, 8'h00);
    chk("R10 reset irq", irq_o, 1'b0);
    @(negedge clk); rst_n = 1;

    // directed corners
    op(0, 1, 0, 8'h8D, 3'b000, 0);                 // R1: bit 7 of index dropped -> 0x0D
    op(1, 0, 1, 8'h00, 3'b000, 0);                 // R10: status reads 0x80
    op(1, 1, 0, 8'h55, 3'b000, 0);                 // R9: write to status ignored
    op(1, 0, 1, 8'h00, 3'b000, 0);
    op(0, 1, 0, 8'h0C, 3'b000, 0);
    op(1, 0, 0, 8'h00, 3'b111, 0);                 // R5: flags set with enables off
    op(1, 1, 0, 8'h00, 3'b000, 0);                 // R9: write to flags ignored
    op(1, 0, 1, 8'h00, 3'b100, 0);                 // R7/R8: read with periodic event
    op(1, 0, 1, 8'h00, 3'b000, 0);                 // R8: periodic flag still pending
    op(1, 0, 1, 8'h00, 3'b000, 0);                 // R7: cleared
    op(0, 1, 0, 8'h0B, 3'b000, 0);
    op(1, 1, 0, 8'h20, 3'b000, 0);                 // R4: alarm enable only
    op(1, 0, 0, 8'h00, 3'b001, 0);                 // R6: update flag, no irq
    op(1, 0, 0, 8'h00, 3'b010, 0);                 // R6: alarm flag -> irq
    op(0, 1, 0, 8'h0A, 3'b000, 1);
    op(1, 1, 0, 8'hFF, 3'b000, 1);                 // R2: bit 7 masked on rate write
    op(1, 0, 1, 8'h00, 3'b000, 1);                 // R3: uip shown in bit 7
    op(0, 0, 1, 8'h00, 3'b000, 0);                 // R3: address 0 reads zero

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic       a, w, r, u;
      logic [7:0] d;
      logic [2:0] ev;
      int         k;
      k  = $urandom_range(0, 9);
      a  = (k >= 3);
      w  = (k < 3) || (k >= 3 && k < 6);
      r  = !w || ($urandom_range(0, 7) == 0);
      d  = 8'($urandom);
      if (!a) d[6:0] = ($urandom_range(0, 3) == 0) ? 7'(d[6:0]) : 7'($urandom_range(9, 14));
      ev = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
      u  = 1'($urandom);
      op(a, w, r, d, ev, u);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule